// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the two I2C wires without ever driving them. It watches SCL and SDA, sampled by a system clock much faster than the bus, and reports the framing conditions it sees. START, repeated START and STOP each appear as a one-cycle pulse. A bus-busy flag stays high from a START until a programmable quiet interval has passed after a STOP. The block also counts clocked bits and marks the acknowledge slot with the level it sampled there.

Each wire first passes through a two-flop synchronizer and then a three-sample majority vote. All detection works on the filtered levels, so a single-cycle spike on either wire is ignored. A START seen while a transfer is open, with no STOP since the last START, is reported as a repeated START. A START that arrives during the quiet interval after a STOP is a plain START. It keeps the bus busy and cancels the pending release.

Top module: `i2c_bus_watch`

## Requirements
- R1: While `rst` is high and in the first cycles after it, `start_o`, `rstart_o`, `stop_o`, `busy_o`, `bit_valid_o`, `ack_valid_o` and `nack_o` are 0 and `bit_index_o` is 0.
- R2: On an idle bus, a falling SDA while SCL is high gives exactly one `start_o` pulse, and `busy_o` is high in that same cycle.
- R3: A falling SDA while SCL is high, with a START taken and no STOP since, gives one `rstart_o` pulse and no `start_o`, and `busy_o` stays high.
- R4: A rising SDA while SCL is high gives exactly one `stop_o` pulse.
- R5: After a STOP on a busy bus, `busy_o` is high for exactly `free_time` cycles, counting the `stop_o` cycle. When `free_time` is 0, `busy_o` is already low in the `stop_o` cycle.
- R6: A START during the post-STOP quiet interval gives `start_o` (not `rstart_o`), and `busy_o` stays high with no release while no further STOP occurs.
- R7: SDA changes while SCL is low produce no condition pulse and no bit.
- R8: Each filtered rising SCL edge while `busy_o` is high gives one `bit_valid_o` pulse, with `bit_value_o` equal to the SDA level. `bit_index_o` then steps 1..9 and wraps from 9 back to 1. A START or repeated START clears `bit_index_o` to 0, and this includes the rising SCL edge that comes before a repeated START or a STOP.
- R9: When `bit_index_o` becomes 9, `ack_valid_o` pulses and `nack_o` takes the SDA level: 0 means ACK and 1 means NACK. `nack_o` holds that value until the next acknowledge slot.
- R10: A level change on either wire that lasts a single system cycle produces no condition pulse and no bit.
- R11: Rising SCL edges while `busy_o` is low are not counted, and `bit_index_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL sample |
| sda_in | input | 1 | Raw SDA sample |
| free_time | input | FREE_W | Bus-free interval after STOP, in system clocks |
| start_o | output | 1 | One-cycle pulse for a START on an idle or releasing bus |
| rstart_o | output | 1 | One-cycle pulse for a repeated START |
| stop_o | output | 1 | One-cycle pulse for a STOP |
| busy_o | output | 1 | Bus busy flag |
| bit_valid_o | output | 1 | One-cycle pulse per counted bit |
| bit_value_o | output | 1 | SDA level of the last counted bit |
| bit_index_o | output | IDX_W | Position of the last counted bit, 0 after a START |
| ack_valid_o | output | 1 | Pulse when the ninth bit is counted |
| nack_o | output | 1 | Level in the last acknowledge slot (1 = NACK) |

## Verification
The bench targets the START that follows a STOP before the quiet interval has expired. A design that only checks the busy flag would report it as a repeated START, or would let busy drop when the old timer runs out. The release length is measured exactly, including a zero interval, so an off-by-one in the reload or the countdown shows up as a wrong cycle count. Single-cycle spikes on SDA while idle and on SCL while busy must leave no trace, which catches a missing or weak majority filter. Bits clocked before a repeated START, bits on an idle bus, and the wrap from the ninth slot back to the first expose counters that reset late, count while idle, or run to ten.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

    // Bits in one transfer unit: eight data bits plus the acknowledge slot
    localparam int BIT_SLOTS = 9;
    localparam int IDX_W     = $clog2(BIT_SLOTS + 1);

    // Filtered line levels; scl is the upper bit
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lv_t;

    // Condition pulses, at most one set per cycle
    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
    } bus_evt_t;

    // Bus ownership state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } bus_st_t;

    function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] cur);
        if (cur == IDX_W'(BIT_SLOTS)) begin
            return IDX_W'(1);
        end
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/busmon_filter.sv
module busmon_filter #(
    parameter int   SYNC = 2,
    parameter int   TAPS = 3,
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic level_q
);

    logic [SYNC-1:0] sync_q;
    logic [TAPS-1:0] tap_q;
    logic            vote;

    // Majority of the sample window
    assign vote = ($countones(tap_q) > (TAPS / 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= {SYNC{INIT}};
            tap_q   <= {TAPS{INIT}};
            level   <= INIT;
            level_q <= INIT;
        end else begin
            sync_q  <= {sync_q[SYNC-2:0], din};
            tap_q   <= {tap_q[TAPS-2:0], sync_q[SYNC-1]};
            level   <= vote;
            level_q <= level;
        end
    end

endmodule

// File: rtl/busmon_cond.sv
module busmon_cond
    import busmon_pkg::*;
#(
    parameter int FREE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_lv_t           now_s,
    input  bus_lv_t           prev_s,
    input  logic [FREE_W-1:0] free_time,
    output bus_evt_t          evt,
    output logic              busy
);

    logic              start_c;
    logic              stop_c;
    bus_st_t           st_q, st_d;
    logic [FREE_W-1:0] cnt_q, cnt_d;
    bus_evt_t          evt_d;

    // SDA edge with SCL held high across both samples
    assign start_c = now_s.scl & prev_s.scl &  prev_s.sda & ~now_s.sda;
    assign stop_c  = now_s.scl & prev_s.scl & ~prev_s.sda &  now_s.sda;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        evt_d = '0;
        if (start_c) begin
            if (st_q == ST_BUSY) begin
                evt_d.rstart = 1'b1;
            end else begin
                evt_d.start = 1'b1;
            end
            st_d  = ST_BUSY;
            cnt_d = '0;
        end else if (stop_c) begin
            evt_d.stop = 1'b1;
            if (st_q != ST_IDLE) begin
                if (free_time == '0) begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else begin
                    st_d  = ST_HOLD;
                    cnt_d = free_time;
                end
            end
        end else if (st_q == ST_HOLD) begin
            if (cnt_q <= FREE_W'(1)) begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            evt   <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            evt   <= evt_d;
        end
    end

    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/busmon_bits.sv
module busmon_bits
    import busmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             restart,
    input  logic             scl_rise,
    input  logic             sda,
    output logic             bit_valid,
    output logic             bit_value,
    output logic [IDX_W-1:0] bit_index,
    output logic             ack_valid,
    output logic             nack
);

    logic [IDX_W-1:0] nxt;

    assign nxt = next_slot(bit_index);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_valid <= 1'b0;
            bit_value <= 1'b0;
            bit_index <= '0;
            ack_valid <= 1'b0;
            nack      <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            ack_valid <= 1'b0;
            if (restart) begin
                bit_index <= '0;
            end else if (busy && scl_rise) begin
                bit_index <= nxt;
                bit_valid <= 1'b1;
                bit_value <= sda;
                if (nxt == IDX_W'(BIT_SLOTS)) begin
                    ack_valid <= 1'b1;
                    nack      <= sda;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import busmon_pkg::*;
#(
    parameter int FREE_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [FREE_W-1:0] free_time,
    output logic              start_o,
    output logic              rstart_o,
    output logic              stop_o,
    output logic              busy_o,
    output logic              bit_valid_o,
    output logic              bit_value_o,
    output logic [IDX_W-1:0]  bit_index_o,
    output logic              ack_valid_o,
    output logic              nack_o
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw_w;
    logic [LINES-1:0] lvl_w;
    logic [LINES-1:0] lvl_q_w;
    bus_lv_t          now_s;
    bus_lv_t          prev_s;
    bus_evt_t         evt;
    logic             busy;
    logic             scl_rise;

    assign raw_w = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        busmon_filter #(
            .SYNC (SYNC_STAGES),
            .TAPS (FILT_TAPS),
            .INIT (1'b1)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .din     (raw_w[g]),
            .level   (lvl_w[g]),
            .level_q (lvl_q_w[g])
        );
    end

    assign now_s    = bus_lv_t'(lvl_w);
    assign prev_s   = bus_lv_t'(lvl_q_w);
    assign scl_rise = now_s.scl & ~prev_s.scl;

    busmon_cond #(
        .FREE_W (FREE_W)
    ) u_cond (
        .clk       (clk),
        .rst       (rst),
        .now_s     (now_s),
        .prev_s    (prev_s),
        .free_time (free_time),
        .evt       (evt),
        .busy      (busy)
    );

    busmon_bits u_bits (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .restart   (evt.start | evt.rstart),
        .scl_rise  (scl_rise),
        .sda       (now_s.sda),
        .bit_valid (bit_valid_o),
        .bit_value (bit_value_o),
        .bit_index (bit_index_o),
        .ack_valid (ack_valid_o),
        .nack      (nack_o)
    );

    assign start_o  = evt.start;
    assign rstart_o = evt.rstart;
    assign stop_o   = evt.stop;
    assign busy_o   = busy;

endmodule

// File: rtl/busmon_checker.sv
module busmon_checker
    import busmon_pkg::*;
#(
    parameter int FREE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [FREE_W-1:0] free_time,
    input logic              start_o,
    input logic              rstart_o,
    input logic              stop_o,
    input logic              busy_o,
    input logic              bit_valid_o,
    input logic [IDX_W-1:0]  bit_index_o,
    input logic              ack_valid_o
);

    // Release window tracker: busy cycles since the last STOP
    logic [FREE_W-1:0] run_q;
    logic [FREE_W-1:0] ft_q;
    logic              armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            ft_q    <= '0;
            armed_q <= 1'b0;
        end else if (stop_o) begin
            run_q   <= FREE_W'(1);
            ft_q    <= free_time;
            armed_q <= busy_o;
        end else if (start_o || rstart_o) begin
            armed_q <= 1'b0;
        end else if (armed_q && busy_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            armed_q <= 1'b0;
        end
    end

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);

    a_r2_busy_rises_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> start_o);

    a_r3_rstart_within_busy: assert property (@(posedge clk) disable iff (rst)
        rstart_o |-> (busy_o && $past(busy_o)));

    a_r4_one_condition: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, rstart_o, stop_o}));

    a_r5_release_length: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !stop_o && $fell(busy_o)) |-> (run_q == ft_q));

    a_r8_index_range: assert property (@(posedge clk) disable iff (rst)
        bit_valid_o |-> (bit_index_o >= IDX_W'(1) && bit_index_o <= IDX_W'(BIT_SLOTS)));

    a_r8_start_clears_index: assert property (@(posedge clk) disable iff (rst)
        (start_o || rstart_o) |=> (bit_index_o == '0));

    a_r9_ack_on_ninth: assert property (@(posedge clk) disable iff (rst)
        ack_valid_o |-> (bit_valid_o && bit_index_o == IDX_W'(BIT_SLOTS)));

endmodule

bind i2c_bus_watch busmon_checker #(
    .FREE_W (FREE_W)
) u_busmon_chk (
    .clk         (clk),
    .rst         (rst),
    .free_time   (free_time),
    .start_o     (start_o),
    .rstart_o    (rstart_o),
    .stop_o      (stop_o),
    .busy_o      (busy_o),
    .bit_valid_o (bit_valid_o),
    .bit_index_o (bit_index_o),
    .ack_valid_o (ack_valid_o)
);

// File: tb/test_i2c_bus_watch.sv
`timescale 1ns/1ps
module test_i2c_bus_watch;

    localparam int FREE_W = 16;
    localparam int H      = 10;

    localparam logic [2:0] OP_START  = 3'd0;
    localparam logic [2:0] OP_STOP   = 3'd1;
    localparam logic [2:0] OP_BIT    = 3'd2;
    localparam logic [2:0] OP_BYTE   = 3'd3;
    localparam logic [2:0] OP_TOGGLE = 3'd4;

    typedef struct packed {
        logic [2:0] op;
        logic [8:0] arg;
        logic       s;
        logic       rs;
        logic       p;
        logic [3:0] bits;
        logic       acks;
        logic       busy;
        logic [3:0] idx;
        logic       val;
        logic       nack;
    } step_t;

    // op, arg, start, rstart, stop, bits, acks, busy, index, value, nack
    localparam step_t STEPS [10] = '{
        '{OP_START,  9'h000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0},
        '{OP_BYTE,   9'h0A5, 1'b0, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 4'd9, 1'b0, 1'b0},
        '{OP_BIT,    9'h001, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b1, 4'd1, 1'b1, 1'b0},
        '{OP_START,  9'h000, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0, 1'b1, 4'd0, 1'b1, 1'b0},
        '{OP_BYTE,   9'h13C, 1'b0, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 4'd9, 1'b1, 1'b1},
        '{OP_TOGGLE, 9'h000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd9, 1'b1, 1'b1},
        '{OP_STOP,   9'h000, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1},
        '{OP_START,  9'h000, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0, 1'b1, 4'd0, 1'b1, 1'b1},
        '{OP_BYTE,   9'h000, 1'b0, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 4'd9, 1'b0, 1'b0},
        '{OP_STOP,   9'h000, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scl_r = 1'b1;
    logic              sda_r = 1'b1;
    logic [FREE_W-1:0] ft = 16'd100;
    logic              start_o, rstart_o, stop_o, busy_o;
    logic              bit_valid_o, bit_value_o, ack_valid_o, nack_o;
    logic [3:0]        bit_index_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_start = 0, n_rstart = 0, n_stop = 0, n_bits = 0, n_acks = 0;
    int run_len = 0;
    logic run_on = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    i2c_bus_watch #(.FREE_W(FREE_W)) i_i2c_bus_watch (
        .clk         (clk),
        .rst         (rst),
        .scl_in      (scl_r),
        .sda_in      (sda_r),
        .free_time   (ft),
        .start_o     (start_o),
        .rstart_o    (rstart_o),
        .stop_o      (stop_o),
        .busy_o      (busy_o),
        .bit_valid_o (bit_valid_o),
        .bit_value_o (bit_value_o),
        .bit_index_o (bit_index_o),
        .ack_valid_o (ack_valid_o),
        .nack_o      (nack_o)
    );

    // Pulse counting and release-length measurement, away from the active edge
    always @(negedge clk) begin
        if (start_o)     n_start++;
        if (rstart_o)    n_rstart++;
        if (stop_o)      n_stop++;
        if (bit_valid_o) n_bits++;
        if (ack_valid_o) n_acks++;
        if (stop_o) begin
            run_len = busy_o ? 1 : 0;
            run_on  = busy_o;
        end else if (run_on) begin
            if (busy_o) run_len++;
            else        run_on = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic phase(input logic c, input logic d);
        @(negedge clk);
        scl_r = c;
        sda_r = d;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        phase(1'b0, sda_r);
        phase(1'b0, 1'b1);
        phase(1'b1, 1'b1);
        phase(1'b1, 1'b0);
        phase(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        phase(1'b0, sda_r);
        phase(1'b0, 1'b0);
        phase(1'b1, 1'b0);
        phase(1'b1, 1'b1);
    endtask

    task automatic do_bit(input logic v);
        phase(1'b0, v);
        phase(1'b1, v);
        phase(1'b0, v);
    endtask

    task automatic do_step(input logic [2:0] op, input logic [8:0] arg);
        case (op)
            OP_START: do_start();
            OP_STOP:  do_stop();
            OP_BIT:   do_bit(arg[0]);
            OP_BYTE: begin
                for (int i = 7; i >= 0; i--) do_bit(arg[i]);
                do_bit(arg[8]);
            end
            default: begin
                phase(1'b0, sda_r);
                phase(1'b0, ~sda_r);
                phase(1'b0, ~sda_r);
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        int b_s, b_rs, b_p, b_b, b_a;

        // R1: reset state
        repeat (10) @(negedge clk);
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 index in reset", bit_index_o, 0);
        rst = 1'b0;
        repeat (12) @(negedge clk);
        settle();
        chk("R1 start", start_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 index", bit_index_o, 0);
        chk("R1 nack", nack_o, 0);
        chk("R1 no pulses", n_start + n_stop + n_bits + n_acks, 0);

        // Table walk
        for (int k = 0; k < 10; k++) begin
            b_s = n_start; b_rs = n_rstart; b_p = n_stop; b_b = n_bits; b_a = n_acks;
            do_step(STEPS[k].op, STEPS[k].arg);
            settle();
            chk((STEPS[k].op == OP_TOGGLE) ? "R7 start count" : "R2 R6 start count",
                n_start - b_s, STEPS[k].s);
            chk((STEPS[k].op == OP_TOGGLE) ? "R7 rstart count" : "R3 rstart count",
                n_rstart - b_rs, STEPS[k].rs);
            chk((STEPS[k].op == OP_TOGGLE) ? "R7 stop count" : "R4 stop count",
                n_stop - b_p, STEPS[k].p);
            chk((STEPS[k].op == OP_TOGGLE) ? "R7 bit count" : "R8 bit count",
                n_bits - b_b, STEPS[k].bits);
            chk("R9 ack count", n_acks - b_a, STEPS[k].acks);
            chk("R2 busy", busy_o, STEPS[k].busy);
            chk("R8 index", bit_index_o, STEPS[k].idx);
            chk("R8 bit value", bit_value_o, STEPS[k].val);
            chk("R9 nack", nack_o, STEPS[k].nack);
        end

        // R5: release after exactly free_time cycles (100)
        repeat (150) @(negedge clk);
        settle();
        chk("R5 busy released", busy_o, 0);
        chk("R5 release length 100", run_len, 100);

        // R11: SCL pulses on an idle bus are not counted
        b_b = n_bits;
        do_bit(1'b1);
        do_bit(1'b1);
        phase(1'b1, 1'b1);
        settle();
        chk("R11 idle bits", n_bits - b_b, 0);
        chk("R11 index kept", bit_index_o, 1);
        chk("R11 busy", busy_o, 0);

        // R10: single-cycle SDA spike with SCL high on idle bus
        b_s = n_start; b_p = n_stop;
        @(negedge clk); sda_r = 1'b0;
        @(negedge clk); sda_r = 1'b1;
        repeat (20) @(negedge clk);
        settle();
        chk("R10 spike start", n_start - b_s, 0);
        chk("R10 spike stop", n_stop - b_p, 0);
        chk("R10 spike busy", busy_o, 0);

        // R5: zero interval
        ft = 16'd0;
        do_start();
        do_stop();
        repeat (20) @(negedge clk);
        settle();
        chk("R5 zero length", run_len, 0);
        chk("R5 zero busy", busy_o, 0);

        // R5: interval 37
        ft = 16'd37;
        do_start();
        do_stop();
        repeat (60) @(negedge clk);
        settle();
        chk("R5 release length 37", run_len, 37);
        chk("R5 busy after 37", busy_o, 0);

        // R6: START inside the quiet interval cancels the release
        ft = 16'd200;
        do_start();
        do_stop();
        b_s = n_start; b_rs = n_rstart;
        do_start();
        settle();
        chk("R6 start during hold", n_start - b_s, 1);
        chk("R6 not repeated", n_rstart - b_rs, 0);
        repeat (400) @(negedge clk);
        settle();
        chk("R6 busy kept", busy_o, 1);

        // R10: single-cycle SCL spike while busy
        b_b = n_bits;
        @(negedge clk); scl_r = 1'b1;
        @(negedge clk); scl_r = 1'b0;
        repeat (20) @(negedge clk);
        settle();
        chk("R10 scl spike bits", n_bits - b_b, 0);
        chk("R10 scl spike index", bit_index_o, 0);
        do_stop();
        repeat (250) @(negedge clk);
        settle();
        chk("R5 busy after 200", busy_o, 0);

        // R1: reset in the middle of a transfer
        do_start();
        do_bit(1'b1);
        @(negedge clk);
        rst   = 1'b1;
        scl_r = 1'b1;
        sda_r = 1'b1;
        repeat (12) @(negedge clk);
        chk("R1 mid reset busy", busy_o, 0);
        chk("R1 mid reset index", bit_index_o, 0);
        b_s = n_start; b_p = n_stop;
        rst = 1'b0;
        repeat (20) @(negedge clk);
        settle();
        chk("R1 after reset busy", busy_o, 0);
        chk("R1 after reset events", (n_start - b_s) + (n_stop - b_p), 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule